// File: doc/BRIEF.md
# Synchronous FIFO with programmable flags

This block is a single-clock first-in, first-out buffer built around a fixed 18 Kb store. A parameter sets the word width to 4, 9, 18 or 36 bits, and the depth follows from it. In the wider shapes, one bit in every nine travels on a separate parity bus beside the data bus. Writes and reads are plain enable-qualified accesses on one clock.

The block reports its fill level on registered flags: empty and full, plus almost-empty and almost-full. Each almost flag has its own 13-bit threshold. An access that cannot be served is dropped, and the block answers it with a one-cycle error pulse. Both pointers are visible as 12-bit counts.

Two optional features change how data leaves the block. In fall-through mode, the oldest stored word is already on the output before any read is issued. An optional output register adds one pipeline stage, with its own clock enable and its own synchronous load of a reset value. At power-up the output shows a parameterised initial word.

Top module: `sync_fifo_pf`

## Requirements
- R1: WIDTH values 4, 9, 18 and 36 give depths of 4096, 2048, 1024 and 512 entries. Data occupies rd_data/wr_data bits [3:0], [7:0], [15:0] and [31:0], and parity occupies rd_par/wr_par bits none, [0], [1:0] and [3:0]. Input bits outside these fields are discarded, and the matching output bits read 0 for stored words.
- R2: Words leave in the order they were accepted. Without fall-through, a read accepted at a clock edge places the oldest word in the first output stage at that edge.
- R3: empty and full are registered from the occupancy after each edge, so they change in the cycle that follows the access that moved occupancy to or from 0 or the depth.
- R4: almost_empty is high exactly when occupancy is at or below AE_OFS. The reset default of AE_OFS is 0x080.
- R5: almost_full is high exactly when free space (depth minus occupancy) is at or below AF_OFS. The reset default of AF_OFS is 0x080.
- R6: A write attempted while full is dropped, leaving wr_cnt and the contents unchanged, and wr_err is high for the single following cycle.
- R7: A read attempted while empty is dropped, leaving rd_cnt unchanged, and rd_err is high for the single following cycle.
- R8: A simultaneous read and write when neither empty nor full keeps occupancy constant. When empty, only the write is performed. When full, only the read is performed.
- R9: With FWFT=1, the oldest word is on rd_data/rd_par from the cycle after it is written, with no read enable. Each accepted read advances the output to the next word. When the FIFO becomes empty, the last word shown is held.
- R10: With OUT_REG=1, the output register loads the first stage only at edges where out_ce is high. out_rst loads RST_VAL at an edge and takes priority over out_ce.
- R11: With OUT_REG=0, out_rst and out_ce have no effect on the outputs.
- R12: From power-up until the first word reaches the output, {rd_par, rd_data} equals INIT_VAL.
- R13: rst is synchronous and active high. While it is high, accesses are ignored, and the pointers and occupancy clear, so that after the edge empty=1, full=0 and both counts are 0. rst should be held for at least 5 cycles.
- R14: rd_cnt and wr_cnt show the read and write pointers zero-extended to 12 bits. The pointers wrap modulo the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high FIFO reset |
| wr_en | input | 1 | Write request |
| wr_data | input | 32 | Write data |
| wr_par | input | 4 | Write parity bits |
| rd_en | input | 1 | Read request |
| out_ce | input | 1 | Output register clock enable |
| out_rst | input | 1 | Output register synchronous load of RST_VAL |
| rd_data | output | 32 | Read data |
| rd_par | output | 4 | Read parity bits |
| empty | output | 1 | No stored words |
| full | output | 1 | All entries in use |
| almost_empty | output | 1 | Occupancy at or below AE_OFS |
| almost_full | output | 1 | Free space at or below AF_OFS |
| wr_err | output | 1 | Pulse after a dropped write |
| rd_err | output | 1 | Pulse after a dropped read |
| rd_cnt | output | 12 | Read pointer |
| wr_cnt | output | 12 | Write pointer |

## Verification
The bench builds two instances side by side:
- A 9-bit-wide instance: 2048 entries, standard read timing, output register on, thresholds 4 and 3.
- A 36-bit-wide instance: 512 entries, fall-through mode, output register off, thresholds 2 and 2.

The small thresholds put both almost-flag edges within a few words of empty and full. The 9-bit shape exercises parity packing and the dropping of unused input bits. The second instance reaches full quickly and shows that the output-register controls have no effect when that stage is absent.

// File: rtl/sync_fifo_pf.sv
module sync_fifo_pf #(
  parameter int          WIDTH    = 36,
  parameter logic [12:0] AE_OFS   = 13'h080,
  parameter logic [12:0] AF_OFS   = 13'h080,
  parameter bit          FWFT     = 1'b0,
  parameter bit          OUT_REG  = 1'b1,
  parameter logic [35:0] INIT_VAL = '0,
  parameter logic [35:0] RST_VAL  = '0
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic [3:0]  wr_par,
  input  logic        rd_en,
  input  logic        out_ce,
  input  logic        out_rst,
  output logic [31:0] rd_data,
  output logic [3:0]  rd_par,
  output logic        empty,
  output logic        full,
  output logic        almost_empty,
  output logic        almost_full,
  output logic        wr_err,
  output logic        rd_err,
  output logic [11:0] rd_cnt,
  output logic [11:0] wr_cnt
);
  localparam int DB    = (WIDTH == 4) ? 4 : WIDTH * 8 / 9;
  localparam int PB    = (WIDTH == 4) ? 0 : WIDTH / 9;
  localparam int PBX   = (PB == 0) ? 1 : PB;
  localparam int EW    = DB + PBX;
  localparam int DEPTH = 16384 / DB;
  localparam int AW    = $clog2(DEPTH);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] rptr, wptr;
  logic [AW:0]   cnt, cnt_nx;
  logic          empty_q = 1'b1;
  logic          full_q, ae_q, af_q, werr_q, rerr_q;
  logic          do_wr, do_rd;
  logic [13:0]   used_nx, free_nx;
  logic [EW-1:0] head;
  logic [35:0]   head36, stage1, dout;
  logic          unused_in;

  assign do_wr   = wr_en & ~full_q & ~rst;
  assign do_rd   = rd_en & ~empty_q & ~rst;
  assign cnt_nx  = cnt + (AW+1)'(do_wr) - (AW+1)'(do_rd);
  assign used_nx = 14'(cnt_nx);
  assign free_nx = 14'(DEPTH) - used_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr    <= '0;
      wptr    <= '0;
      cnt     <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      ae_q    <= 1'b1;
      af_q    <= (14'(DEPTH) <= 14'(AF_OFS));
      werr_q  <= 1'b0;
      rerr_q  <= 1'b0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
      cnt     <= cnt_nx;
      empty_q <= (cnt_nx == '0);
      full_q  <= (used_nx == 14'(DEPTH));
      ae_q    <= (used_nx <= 14'(AE_OFS));
      af_q    <= (free_nx <= 14'(AF_OFS));
      werr_q  <= wr_en & full_q;
      rerr_q  <= rd_en & empty_q;
    end
  end

  always_ff @(posedge clk)
    if (do_wr) mem[wptr] <= {wr_par[PBX-1:0], wr_data[DB-1:0]};

  assign head   = mem[rptr];
  assign head36 = {(PB == 0) ? 4'd0 : 4'(head[EW-1:DB]), 32'(head[DB-1:0])};

  if (FWFT) begin : g_fwft
    logic [35:0] last_q = INIT_VAL;
    assign stage1 = empty_q ? last_q : head36;
    always_ff @(posedge clk) last_q <= stage1;
  end else begin : g_std
    logic [35:0] rd_q = INIT_VAL;
    assign stage1 = rd_q;
    always_ff @(posedge clk) if (do_rd) rd_q <= head36;
  end

  if (OUT_REG) begin : g_oreg
    logic [35:0] o_q = INIT_VAL;
    always_ff @(posedge clk)
      if (out_rst)     o_q <= RST_VAL;
      else if (out_ce) o_q <= stage1;
    assign dout = o_q;
  end else begin : g_noreg
    assign dout = stage1;
  end

  assign rd_data      = dout[31:0];
  assign rd_par       = dout[35:32];
  assign empty        = empty_q;
  assign full         = full_q;
  assign almost_empty = ae_q;
  assign almost_full  = af_q;
  assign wr_err       = werr_q;
  assign rd_err       = rerr_q;
  assign rd_cnt       = 12'(rptr);
  assign wr_cnt       = 12'(wptr);
  assign unused_in    = ^{wr_data, wr_par, out_ce, out_rst};
endmodule

// File: rtl/sync_fifo_pf_chk.sv
module sync_fifo_pf_chk #(
  parameter bit OUT_REG = 1'b1
)(
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        rd_en,
  input logic        out_ce,
  input logic        out_rst,
  input logic        empty,
  input logic        full,
  input logic        wr_err,
  input logic        rd_err,
  input logic [11:0] rd_cnt,
  input logic [11:0] wr_cnt,
  input logic [31:0] rd_data,
  input logic [3:0]  rd_par
);
  a_r3_not_both: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));
  a_r6_wr_err_pulse: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full) |=> wr_err);
  a_r6_full_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && full) |=> (full && $stable(wr_cnt)));
  a_r7_rd_err_pulse: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> rd_err);
  a_r7_empty_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && empty) |=> (empty && $stable(rd_cnt)));
  a_r8_level_kept: assert property (@(posedge clk) disable iff (rst)
    (rd_en && wr_en && !empty && !full) |=> ($stable(empty) && $stable(full)));
  a_r10_out_hold: assert property (@(posedge clk) disable iff (rst)
    (OUT_REG && !out_rst && !out_ce) |=> $stable({rd_par, rd_data}));
endmodule

bind sync_fifo_pf sync_fifo_pf_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .out_ce(out_ce),
  .out_rst(out_rst), .empty(empty), .full(full), .wr_err(wr_err),
  .rd_err(rd_err), .rd_cnt(rd_cnt), .wr_cnt(wr_cnt), .rd_data(rd_data),
  .rd_par(rd_par)
);

// File: tb/sync_fifo_pf_test.sv
`timescale 1ns/1ps
module sync_fifo_pf_test;
  localparam logic [35:0] A_INIT = 36'h9_1357_9BDF;
  localparam logic [35:0] A_RST  = 36'h6_0F0F_A5A5;
  localparam logic [35:0] B_INIT = 36'h3_CAFE_F00D;
  localparam int A_DEP = 2048, A_AE = 4, A_AF = 3;
  localparam int B_DEP = 512,  B_AE = 2, B_AF = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic a_we = 0, a_re = 0, a_ce = 1, a_orst = 0;
  logic [31:0] a_d = 0;
  logic [3:0]  a_p = 0;
  logic [31:0] a_rd; logic [3:0] a_rp;
  logic a_em, a_fu, a_ae, a_af, a_werr, a_rerr;
  logic [11:0] a_rc, a_wc;

  logic b_we = 0, b_re = 0, b_ce = 0, b_orst = 0;
  logic [31:0] b_d = 0;
  logic [3:0]  b_p = 0;
  logic [31:0] b_rd; logic [3:0] b_rp;
  logic b_em, b_fu, b_ae, b_af, b_werr, b_rerr;
  logic [11:0] b_rc, b_wc;

  sync_fifo_pf #(.WIDTH(9), .AE_OFS(13'd4), .AF_OFS(13'd3), .FWFT(1'b0),
    .OUT_REG(1'b1), .INIT_VAL(A_INIT), .RST_VAL(A_RST)) uut (
    .clk(clk), .rst(rst), .wr_en(a_we), .wr_data(a_d), .wr_par(a_p),
    .rd_en(a_re), .out_ce(a_ce), .out_rst(a_orst), .rd_data(a_rd),
    .rd_par(a_rp), .empty(a_em), .full(a_fu), .almost_empty(a_ae),
    .almost_full(a_af), .wr_err(a_werr), .rd_err(a_rerr), .rd_cnt(a_rc),
    .wr_cnt(a_wc));

  sync_fifo_pf #(.WIDTH(36), .AE_OFS(13'd2), .AF_OFS(13'd2), .FWFT(1'b1),
    .OUT_REG(1'b0), .INIT_VAL(B_INIT), .RST_VAL(36'hF_FFFF_FFFF)) uut_fw (
    .clk(clk), .rst(rst), .wr_en(b_we), .wr_data(b_d), .wr_par(b_p),
    .rd_en(b_re), .out_ce(b_ce), .out_rst(b_orst), .rd_data(b_rd),
    .rd_par(b_rp), .empty(b_em), .full(b_fu), .almost_empty(b_ae),
    .almost_full(b_af), .wr_err(b_werr), .rd_err(b_rerr), .rd_cnt(b_rc),
    .wr_cnt(b_wc));

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_tag = "R12";

  logic [8:0]  aq [A_DEP];
  int a_cnt = 0, a_rpi = 0, a_wpi = 0;
  logic [35:0] a_s1 = A_INIT, a_s2 = A_INIT;
  bit a_xw = 0, a_xr = 0;

  logic [35:0] bq [B_DEP];
  int b_cnt = 0, b_rpi = 0, b_wpi = 0;
  logic [35:0] b_last = B_INIT;
  bit b_xw = 0, b_xr = 0;

  task automatic chk(string rq, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (phase %s) actual=%h expected=%h t=%0t", rq, cur_tag, act, exp, $time);
    end
  endtask

  function automatic logic [35:0] b_view();
    return (b_cnt == 0) ? b_last : bq[b_rpi];
  endfunction

  task automatic model_edge();
    logic [35:0] old_s1;
    bit dw, dr;
    old_s1 = a_s1;
    if (rst) begin
      a_cnt = 0; a_rpi = 0; a_wpi = 0; a_xw = 0; a_xr = 0;
    end else begin
      dw = a_we && (a_cnt < A_DEP);
      dr = a_re && (a_cnt > 0);
      a_xw = a_we && (a_cnt == A_DEP);
      a_xr = a_re && (a_cnt == 0);
      if (dr) begin
        a_s1 = {3'b0, aq[a_rpi][8], 24'b0, aq[a_rpi][7:0]};
        a_rpi = (a_rpi + 1) % A_DEP;
      end
      if (dw) begin
        aq[a_wpi] = {a_p[0], a_d[7:0]};
        a_wpi = (a_wpi + 1) % A_DEP;
      end
      a_cnt = a_cnt + int'(dw) - int'(dr);
    end
    if (a_orst) a_s2 = A_RST;
    else if (a_ce) a_s2 = old_s1;

    b_last = b_view();
    if (rst) begin
      b_cnt = 0; b_rpi = 0; b_wpi = 0; b_xw = 0; b_xr = 0;
    end else begin
      dw = b_we && (b_cnt < B_DEP);
      dr = b_re && (b_cnt > 0);
      b_xw = b_we && (b_cnt == B_DEP);
      b_xr = b_re && (b_cnt == 0);
      if (dr) b_rpi = (b_rpi + 1) % B_DEP;
      if (dw) begin
        bq[b_wpi] = {b_p, b_d};
        b_wpi = (b_wpi + 1) % B_DEP;
      end
      b_cnt = b_cnt + int'(dw) - int'(dr);
    end
  endtask

  task automatic compare();
    chk(cur_tag, {a_rp, a_rd}, a_s2);
    chk("R3", {34'b0, a_em, a_fu}, {34'b0, a_cnt == 0, a_cnt == A_DEP});
    chk("R4", 36'(a_ae), 36'(a_cnt <= A_AE));
    chk("R5", 36'(a_af), 36'((A_DEP - a_cnt) <= A_AF));
    chk("R6", 36'(a_werr), 36'(a_xw));
    chk("R7", 36'(a_rerr), 36'(a_xr));
    chk("R14", {12'b0, a_rc, a_wc}, {12'b0, 12'(a_rpi), 12'(a_wpi)});
    chk(cur_tag, {b_rp, b_rd}, b_view());
    chk("R3", {34'b0, b_em, b_fu}, {34'b0, b_cnt == 0, b_cnt == B_DEP});
    chk("R4", 36'(b_ae), 36'(b_cnt <= B_AE));
    chk("R5", 36'(b_af), 36'((B_DEP - b_cnt) <= B_AF));
    chk("R6", 36'(b_werr), 36'(b_xw));
    chk("R7", 36'(b_rerr), 36'(b_xr));
    chk("R14", {12'b0, b_rc, b_wc}, {12'b0, 12'(b_rpi), 12'(b_wpi)});
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic idle();
    a_we = 0; a_re = 0; b_we = 0; b_re = 0;
  endtask

  initial begin
    void'($urandom(32'd2718));
    // R12 and R13: power-up value on the output, accesses ignored under reset
    a_we = 1; a_re = 1; b_we = 1; b_re = 1;
    a_d = 32'hDEAD_BE11; b_d = 32'h1111_2222;
    cur_tag = "R12";
    cyc(6);
    rst = 0; idle();
    cyc(2);

    // R2: ordered transfer, almost-empty edge (R4)
    cur_tag = "R2";
    for (int i = 0; i < 6; i++) begin
      a_we = 1; a_d = 32'hABCD_0010 + 32'(i); a_p = 4'(i);
      cyc();
    end
    idle();
    for (int i = 0; i < 7; i++) begin a_re = 1; cyc(); end
    idle(); cyc(2);

    // R10: output register hold and load
    cur_tag = "R10";
    a_we = 1; a_d = 32'h55; a_p = 4'h1; cyc();
    a_we = 0; a_ce = 0; a_re = 1; cyc();
    a_re = 0; cyc(3);
    a_orst = 1; a_ce = 1; cyc();
    a_orst = 0; a_ce = 0; cyc(2);
    a_ce = 1; cyc(2);

    // R9: fall-through shows first word without a read
    cur_tag = "R9";
    b_we = 1; b_d = 32'h0BAD_CAFE; b_p = 4'hA; cyc();
    b_we = 1; b_d = 32'h1234_5678; b_p = 4'h5; cyc();
    b_we = 0; cyc(2);
    b_re = 1; cyc(); b_re = 1; cyc(); b_re = 1; cyc();
    b_re = 0; cyc(2);

    // R11: output-register controls on an instance without one
    cur_tag = "R11";
    b_we = 1; b_d = 32'h7777_0001; b_p = 4'h3; cyc();
    b_we = 0; b_orst = 1; b_ce = 1; cyc(3);
    b_orst = 0; b_ce = 0; cyc();

    // R6 and R5: fill both to full, then write into full
    cur_tag = "R1";
    a_we = 1; b_we = 1;
    for (int i = 0; i < A_DEP + 3; i++) begin
      a_d = $urandom; a_p = 4'($urandom);
      b_d = $urandom; b_p = 4'($urandom);
      cyc();
    end
    // R8: simultaneous access while full: read only
    cur_tag = "R8";
    a_we = 1; a_re = 1; b_we = 1; b_re = 1; cyc();
    cyc(3);
    idle(); cyc();
    // drain both, then R8 while empty: write only
    a_re = 1; b_re = 1;
    for (int i = 0; i < A_DEP + 3; i++) cyc();
    a_we = 1; b_we = 1; a_d = 32'hC3; b_d = 32'hC3C3_C3C3; cyc();
    a_we = 1; a_re = 1; b_we = 1; b_re = 1; cyc(4);
    idle(); cyc(2);

    // R1 and R14: random traffic with wrap-around
    cur_tag = "R1";
    for (int i = 0; i < 6000; i++) begin
      a_we = ($urandom % 100) < 55; a_re = ($urandom % 100) < 50;
      b_we = ($urandom % 100) < 50; b_re = ($urandom % 100) < 50;
      a_ce = ($urandom % 4) != 0; a_orst = ($urandom % 40) == 0;
      b_ce = $urandom; b_orst = ($urandom % 10) == 0;
      a_d = $urandom; a_p = 4'($urandom);
      b_d = $urandom; b_p = 4'($urandom);
      cyc();
    end
    a_ce = 1; a_orst = 0; b_orst = 0;

    // R13: mid-run reset with data stored
    cur_tag = "R13";
    a_we = 1; b_we = 1; cyc(8);
    rst = 1; a_re = 1; b_re = 1; cyc(5);
    rst = 0; idle(); cyc(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired t=%0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule